// File: doc/BRIEF.md
# Mode-Selectable Addressable Latch and 1-of-N Demultiplexer

This block is a bank of single-bit storage cells with one parallel output word. Two active-low controls, an enable and a clear, form a two-bit mode that selects one of four behaviours.

- **Write mode:** one data bit is written into the cell picked by a binary address.
- **Hold mode:** the whole bank is frozen.
- **Demultiplexer mode:** the data bit is steered to the addressed output and every other output is forced low.
- **Clear mode:** the whole word is forced to zero.

It is a clocked, register-based model of a transparent addressable latch. The output word is combinational from the current inputs and the stored word, so the addressed bit follows the data input within the same cycle. On each rising clock edge the stored word takes whatever the outputs show. A later switch to hold mode therefore keeps exactly what was visible before, including the results of demultiplexer or clear cycles.

A system reset clears the stored word. The address may change only while the enable is high, which covers hold and clear. Changing it while the enable is low can cause a wrong cell to be written, and a bound checker flags such a change.

Top module: `addr_latch_demux`

## Requirements
- R1: With en_n=0 and clr_n=1 (write mode), output bit q[addr] equals din in the same cycle, before any clock edge.
- R2: In write mode, every output bit other than q[addr] keeps the value it had in the previous cycle.
- R3: With en_n=1 and clr_n=1 (hold mode), q equals the stored word whatever addr and din are.
- R4: With en_n=0 and clr_n=0 (demultiplexer mode), q[addr] equals din and all other bits of q are 0.
- R5: With en_n=1 and clr_n=0 (clear mode), q is all zeros whatever addr and din are.
- R6: The address is an unsigned binary number with bit 0 as the LSB. Address 0 selects q[0] and address 2**ADDR_W-1 selects the top bit.
- R7: On every rising clock edge the stored word takes the value q shows. A following hold cycle therefore keeps the demultiplexer or clear result, and leaving clear mode brings back no earlier data.
- R8: addr changes only in cycles where en_n is 1. Across two consecutive cycles with en_n=0, addr stays stable.
- R9: While rst_n is low the stored word is cleared, so the first hold cycle after reset shows all zeros.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the stored word updates on the rising edge |
| rst_n | input | 1 | Asynchronous active-low system reset of the stored word |
| addr | input | ADDR_W | Binary cell select, bit 0 is the LSB |
| din | input | 1 | Data bit to write or steer |
| en_n | input | 1 | Active-low enable (mode bit 1) |
| clr_n | input | 1 | Active-low clear (mode bit 0) |
| q | output | 2**ADDR_W | Parallel output word |

## Verification
Every output result of the four modes is due in the cycle the inputs are applied, with zero latency. The bench drives inputs just after a falling edge and compares q one nanosecond later, before the next rising edge. Stored effects (R2, R3, R7, R9) become due one rising edge later. The bench's reference word is updated only after that edge, and the following hold cycle then checks it. Every new address is presented during a hold cycle, which both respects R8 and checks that the address change left q untouched.

// File: rtl/ald_pkg.sv
package ald_pkg;
    // mode code is {en_n, clr_n}
    typedef enum logic [1:0] {
        MODE_DEMUX = 2'b00,
        MODE_WRITE = 2'b01,
        MODE_CLEAR = 2'b10,
        MODE_HOLD  = 2'b11
    } ald_mode_e;

    function automatic ald_mode_e to_mode(input logic en_n, input logic clr_n);
        return ald_mode_e'({en_n, clr_n});
    endfunction
endpackage

// File: rtl/ald_addr_dec.sv
module ald_addr_dec #(
    parameter int ADDR_W = 3,
    localparam int N_OUT = 1 << ADDR_W
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [N_OUT-1:0]  sel
);
    for (genvar i = 0; i < N_OUT; i++) begin : g_sel
        assign sel[i] = (addr == ADDR_W'(i));
    end
endmodule

// File: rtl/ald_out_sel.sv
module ald_out_sel
    import ald_pkg::*;
#(
    parameter int N_OUT = 8
) (
    input  ald_mode_e         mode,
    input  logic [N_OUT-1:0]  sel,
    input  logic              din,
    input  logic [N_OUT-1:0]  stored,
    output logic [N_OUT-1:0]  q
);
    logic [N_OUT-1:0] din_vec;

    assign din_vec = {N_OUT{din}};

    always_comb begin
        unique case (mode)
            MODE_WRITE: q = (stored & ~sel) | (din_vec & sel);
            MODE_HOLD:  q = stored;
            MODE_DEMUX: q = din_vec & sel;
            default:    q = '0;
        endcase
    end
endmodule

// File: rtl/addr_latch_demux.sv
module addr_latch_demux
    import ald_pkg::*;
#(
    parameter int ADDR_W = 3,
    localparam int N_OUT = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              din,
    input  logic              en_n,
    input  logic              clr_n,
    output logic [N_OUT-1:0]  q
);
    typedef struct packed {
        logic [N_OUT-1:0] bits;
    } ald_state_t;

    ald_state_t       st_d, st_q;
    ald_mode_e        mode;
    logic [N_OUT-1:0] sel;
    logic [N_OUT-1:0] q_comb;

    assign mode = to_mode(en_n, clr_n);

    ald_addr_dec #(.ADDR_W(ADDR_W)) u_dec (
        .addr (addr),
        .sel  (sel)
    );

    ald_out_sel #(.N_OUT(N_OUT)) u_sel (
        .mode   (mode),
        .sel    (sel),
        .din    (din),
        .stored (st_q.bits),
        .q      (q_comb)
    );

    // next stored word is whatever the outputs currently show
    always_comb begin
        st_d      = st_q;
        st_d.bits = q_comb;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign q = q_comb;
endmodule

// File: rtl/ald_chk.sv
module ald_chk #(
    parameter int ADDR_W = 3,
    localparam int N_OUT = 1 << ADDR_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] addr,
    input logic              din,
    input logic              en_n,
    input logic              clr_n,
    input logic [N_OUT-1:0]  q
);
    logic             armed_q;
    logic [N_OUT-1:0] hot;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) armed_q <= 1'b0;
        else        armed_q <= 1'b1;
    end

    assign hot = N_OUT'(1) << addr;

    a_r1_addr_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_n && clr_n) |-> (q[addr] == din));

    a_r2_others_keep: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && !en_n && clr_n) |-> ((q & ~hot) == ($past(q) & ~hot)));

    a_r3_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && en_n && clr_n) |-> (q == $past(q)));

    a_r4_demux_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_n && !clr_n) |-> (q == (din ? hot : '0)));

    a_r5_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (en_n && !clr_n) |-> (q == '0));

    a_r8_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && !en_n && !$past(en_n)) |-> $stable(addr));
endmodule

bind addr_latch_demux ald_chk #(.ADDR_W(ADDR_W)) u_ald_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .addr  (addr),
    .din   (din),
    .en_n  (en_n),
    .clr_n (clr_n),
    .q     (q)
);

// File: tb/addr_latch_demux_tb_top.sv
module addr_latch_demux_tb_top;
    localparam int AW = 3;
    localparam int NO = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic          din = 1'b0;
    logic          en_n = 1'b1;
    logic          clr_n = 1'b1;
    logic [NO-1:0] q;

    int            n_chk = 0;
    int            n_err = 0;
    logic [NO-1:0] model = '0;
    bit            done = 1'b0;

    always #2.5 clk = ~clk;

    addr_latch_demux #(.ADDR_W(AW)) dut_i (
        .clk(clk), .rst_n(rst_n), .addr(addr), .din(din),
        .en_n(en_n), .clr_n(clr_n), .q(q)
    );

    function automatic logic [NO-1:0] expect_q(input logic e, input logic c,
                                               input logic [AW-1:0] a, input logic d,
                                               input logic [NO-1:0] st);
        logic [NO-1:0] r;
        r = st;
        case ({e, c})
            2'b01: r[a] = d;                 // write
            2'b11: r = st;                   // hold
            2'b00: begin r = '0; r[a] = d; end // demux
            default: r = '0;                 // clear
        endcase
        return r;
    endfunction

    task automatic check(input string req, input logic [NO-1:0] exp);
        n_chk++;
        if (q !== exp) begin
            n_err++;
            $display("FAIL %s: q=%b expected=%b", req, q, exp);
        end
    endtask

    // one step: hold cycle with new address (R8), then the requested mode
    task automatic step(input logic e, input logic c, input logic [AW-1:0] a,
                        input logic d, input string req);
        @(negedge clk);
        en_n = 1'b1; clr_n = 1'b1; addr = a; din = ~d;
        #1 check("R3/R8", model);
        @(negedge clk);
        en_n = e; clr_n = c; din = d;
        #1 check(req, expect_q(e, c, a, d, model));
        model = expect_q(e, c, a, d, model);
    endtask

    initial begin
        logic [NO-1:0] snap;
        void'($urandom(32'h5eed_1234));
        #1 check("R9", '0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1 check("R9", '0);

        // R6: walk a one through every address
        for (int a = 0; a < NO; a++) begin
            step(1'b0, 1'b1, AW'(a), 1'b1, "R1/R6");
            check("R6", (NO'(2) << a) - NO'(1));
        end
        // all four modes crossed with every address
        for (int m = 0; m < 4; m++) begin
            for (int a = 0; a < NO; a++) begin
                step(m[1], m[0], AW'(a), 1'($urandom), "R1/R2/R3/R4/R5");
            end
        end
        // R7: demux result kept by following hold
        step(1'b0, 1'b0, 3'd5, 1'b1, "R4");
        step(1'b1, 1'b1, 3'd2, 1'b1, "R7");
        check("R7", NO'(1) << 5);
        // R2: write then hold keeps earlier bits
        step(1'b0, 1'b1, 3'd0, 1'b1, "R1");
        step(1'b0, 1'b1, 3'd7, 1'b1, "R2");
        snap = q;
        step(1'b1, 1'b1, 3'd3, 1'b0, "R3");
        check("R2", snap);
        // R7: leaving clear restores nothing
        step(1'b1, 1'b0, 3'd4, 1'b1, "R5");
        step(1'b0, 1'b1, 3'd3, 1'b1, "R7");
        check("R7", NO'(1) << 3);
        // random traffic
        for (int i = 0; i < 300; i++) begin
            step(1'($urandom), 1'($urandom), AW'($urandom), 1'($urandom), "R1-R5 random");
        end
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule